// File: doc/BRIEF.md
# Ring-Counter Successive Approximation Controller

This block is the digital half of a small successive-approximation converter. It produces the trial code for an external DAC and reads back a single comparator decision each clock. It then settles the code one bit at a time, starting at the most significant bit. The comparator, the DAC and the sample-and-hold stay outside the block.

A one-hot token walks down a ring of flops, one position for each code bit. The bit that holds the token takes the comparator decision on the next edge. On that same edge the bit below it is raised as the new trial. There is no binary step counter. A conversion starts when the active-low start strobe is sampled low on a rising edge. The finished code is copied into a result register, and an end-of-conversion pulse marks that copy.

Top module: `sar_ring_ctrl`

## Requirements
- R1: After asynchronous reset, trial and result are 0000 and eoc is 0. While start_n stays high, trial keeps that value and eoc stays 0.
- R2: A rising edge that samples start_n low loads trial with 1000: only bit 3, the MSB, is set.
- R3: On each later edge, the bit holding the token keeps a 1 when cmp is 1 and is cleared when cmp is 0. The next lower bit is then set. With a held input of 11 (cmp = input >= trial), trial runs 1000, 1100, 1010, 1011.
- R4: cmp equal to 1 at equality keeps the bit, so an input that exactly equals the final trial converts to that exact code.
- R5: eoc is high for exactly one cycle. It follows the edge that captures the LSB decision, which is the 5th edge counting the start edge. On that edge result takes the final code.
- R6: result changes only on an edge that raises eoc. Between those edges it holds its value.
- R7: A start strobe sampled during a conversion restarts it from 1000. That includes the edge that would capture the LSB. No eoc is issued and result is left unchanged.
- R8: After a conversion ends, trial holds the final code, and no further eoc appears until the next start.
- R9: For every input 0 to 15, the converted result equals the input. This also holds when starts repeat every 5 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Start-of-conversion strobe, active low, sampled on the clock |
| cmp | input | 1 | Comparator decision: 1 when held input >= DAC level |
| trial | output | 4 | Current trial code sent to the DAC |
| result | output | 4 | Last completed conversion result |
| eoc | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The LSB capture and a fresh start strobe can fall on the same rising edge. The block must then give the restart priority. The bench provokes this by pulling start_n low just before the 5th edge of a running conversion, with a new input value applied. On that edge it expects trial to return to 1000, no eoc, and result still holding the previous conversion. The bench also runs starts every 5 clocks, so each eoc pulse is followed at once by the next start edge, and it checks that neither event corrupts the other.

// File: rtl/sar_ring_ctrl.sv
module sar_ring_ctrl #(
  parameter int NBITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             cmp,
  output logic [NBITS-1:0] trial,
  output logic [NBITS-1:0] result,
  output logic             eoc
);

  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] ring;
  logic [NBITS:0]   ring_up;
  logic             go;
  logic             done;

  assign go      = ~start_n;
  assign done    = start_n & ring[0];
  assign ring_up = {1'b0, ring};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ring <= '0;
    else if (go) ring <= TOP_BIT;
    else         ring <= ring >> 1;
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              trial[i] <= 1'b0;
      else if (go)             trial[i] <= TOP_BIT[i];
      else if (ring[i])        trial[i] <= cmp;
      else if (ring_up[i+1])   trial[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc    <= 1'b0;
      result <= '0;
    end else begin
      eoc <= done;
      if (done) result <= {trial[NBITS-1:1], cmp};
    end
  end

endmodule

module sar_ring_ctrl_chk #(
  parameter int NBITS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_n,
  input logic             cmp,
  input logic [NBITS-1:0] trial,
  input logic [NBITS-1:0] result,
  input logic             eoc,
  input logic [NBITS-1:0] ring
);

  localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

  a_r2_start_loads_msb: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> trial == MSB_ONLY);

  a_r3_keep_grows: assert property (@(posedge clk) disable iff (!rst_n)
    start_n && cmp && (ring != '0) |=> trial >= $past(trial));

  a_r3_clear_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    start_n && !cmp && (ring != '0) |=> trial < $past(trial));

  a_r5_eoc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(result));

  a_r7_restart_no_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> !eoc);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_n && (ring == '0) |=> $stable(trial) && !eoc);

  a_r1_ring_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ring));

endmodule

bind sar_ring_ctrl sar_ring_ctrl_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmp(cmp),
  .trial(trial), .result(result), .eoc(eoc), .ring(ring)
);

// File: tb/sar_ring_ctrl_test.sv
module sar_ring_ctrl_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       cmp;
  logic [3:0] trial;
  logic [3:0] result;
  logic       eoc;
  int         vin = 0;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;
  int         last_res = 0;

  always #(CLK_P/2) clk = ~clk;

  assign cmp = (vin >= int'(trial));

  sar_ring_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmp(cmp),
    .trial(trial), .result(result), .eoc(eoc)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Called just after the start edge; runs the remaining four edges.
  task automatic finish_conv(input int v);
    chk("R2 trial after start", int'(trial), 8);
    chk("R7 no eoc after start", int'(eoc), 0);
    for (int b = 3; b >= 1; b--) begin
      tick();
      chk("R3 trial step", int'(trial), ((v >> b) << b) | (1 << (b - 1)));
      chk("R6 result held", int'(result), last_res);
    end
    tick();
    chk("R5 eoc pulse", int'(eoc), 1);
    chk("R4 R9 final code", int'(result), v);
    last_res = v;
  endtask

  task automatic conv(input int v);
    vin = v;
    start_n = 1'b0;
    tick();
    start_n = 1'b1;
    finish_conv(v);
    tick();
    chk("R5 eoc single", int'(eoc), 0);
    chk("R8 trial holds", int'(trial), v);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    chk("R1 reset trial", int'(trial), 0);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset eoc", int'(eoc), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R1 idle trial", int'(trial), 0);
      chk("R1 idle eoc", int'(eoc), 0);
    end

    conv(11);

    for (int v = 0; v < 16; v++) begin
      conv(v);
      for (int k = 0; k < 2; k++) begin
        tick();
        chk("R8 no eoc idle", int'(eoc), 0);
        chk("R8 trial idle", int'(trial), v);
      end
    end

    // back-to-back starts every 5 clocks
    for (int j = 0; j < 6; j++) begin
      vin = (j * 7 + 3) % 16;
      start_n = 1'b0;
      tick();
      start_n = 1'b1;
      finish_conv(vin);
    end
    tick();
    chk("R5 eoc falls", int'(eoc), 0);

    // restart mid conversion
    vin = 5;
    start_n = 1'b0;
    tick();
    start_n = 1'b1;
    tick();
    vin = 12;
    start_n = 1'b0;
    tick();
    start_n = 1'b1;
    chk("R7 mid restart result", int'(result), last_res);
    finish_conv(12);

    // start collides with LSB capture edge
    vin = 6;
    start_n = 1'b0;
    tick();
    start_n = 1'b1;
    tick();
    tick();
    tick();
    vin = 9;
    start_n = 1'b0;
    tick();
    start_n = 1'b1;
    chk("R7 collision no eoc", int'(eoc), 0);
    chk("R7 collision result kept", int'(result), 12);
    finish_conv(9);
    tick();
    chk("R8 after collision", int'(trial), 9);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule